// File: doc/BRIEF.md
# Bounded Line Fetch Address Generator

This block turns a byte-granular read job into a series of 64-byte line requests for an input bitstream held in memory. A job is set up with a page-aligned base address, a byte offset added to that base, a byte length and an optional fence address. A single start pulse takes a snapshot of all of these. The block then presents one line address at a time on a valid/ready request port. Each request carries a byte-enable mask, so the partial head and tail lines mark only the bytes that belong to the job.

The fence is an upper limit on addresses. Once the line about to be requested lies at or above the fence, no further request is issued. The job then ends with a sticky bound-hit flag raised next to the done flag. A fence value of zero turns the check off. A memory fetch engine or a stream reader sits downstream and consumes the requests. Software or a command parser starts each job and watches the done and bound-hit flags.

Top module: `bfetch_gen`

## Requirements
- R1: The job start byte address is the base with its low 12 bits forced to zero, plus the 29-bit offset. The first request address is this start address rounded down to a multiple of 64.
- R2: Each accepted request advances the address by 64. The job issues exactly one request per line from the start line through the line holding byte start+length-1, then sets done on the clock edge of the last handshake.
- R3: Bit i of the byte enable stands for byte i of the line (address bits 5:0 equal to i). The first line enables bits from start[5:0] upward. The last line enables bits up to (start+length-1)[5:0]. A line that is both first and last applies both limits. Every other line enables all 64 bits.
- R4: While the request is valid and not ready, the address and the byte enable hold unchanged and valid stays high.
- R5: The length is a 28-bit byte count. A length of zero issues no request and sets done on the same clock edge that accepts the start.
- R6: With a non-zero fence (fence input with its low 12 bits cleared), a line whose address is at or above the fence is never requested. When such a line becomes current, done and bound-hit are both set on the next edge.
- R7: A fence whose upper 52 bits are all zero disables the check, including when only its low 12 bits are set.
- R8: Done and bound-hit stay set until the next accepted start, which clears both.
- R9: A start pulse is accepted only while no job runs. Start pulses and input changes during a running job have no effect on it.
- R10: After reset, valid, done and bound-hit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; captures the job inputs when idle |
| base_i | input | 64 | Base address; low 12 bits ignored |
| offset_i | input | 29 | Byte offset from the base |
| length_i | input | 28 | Job length in bytes |
| bound_i | input | 64 | Fence address; low 12 bits ignored, zero disables |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted by the consumer |
| req_addr_o | output | 64 | Line address of the request (64-byte aligned) |
| req_be_o | output | 64 | Byte enables for the requested line |
| done_o | output | 1 | Job finished (sticky until next start) |
| bound_hit_o | output | 1 | Job stopped by the fence (sticky until next start) |

## Verification
A start seen at one rising edge makes the first request visible right after that edge. For a zero length, done appears right after that same edge instead. The next line address appears right after the edge that completes a handshake. Done follows the edge of the last handshake. Bound-hit and done follow the first edge at which the current line lies at or above the fence. The bench drives its inputs shortly after each rising edge and steps a behavioural model at the rising edge. It compares every output against that model at the falling edge, so each result is checked in the exact cycle it is due. It also checks the request count and the flags of each whole job.

// File: rtl/bfetch_pkg.sv
package bfetch_pkg;

    localparam int unsigned DEF_ADDR_W     = 64;
    localparam int unsigned DEF_OFFS_W     = 29;
    localparam int unsigned DEF_LEN_W      = 28;
    localparam int unsigned DEF_LINE_BYTES = 64;
    localparam int unsigned DEF_PAGE_BYTES = 4096;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_RUN  = 1'b1
    } fstate_e;

endpackage

// File: rtl/bfetch_bemask.sv
module bfetch_bemask #(
    parameter int unsigned LINE_BYTES = bfetch_pkg::DEF_LINE_BYTES,
    localparam int unsigned LINE_SHIFT = $clog2(LINE_BYTES)
) (
    input  logic                  first_i,
    input  logic                  last_i,
    input  logic [LINE_SHIFT-1:0] head_i,
    input  logic [LINE_SHIFT-1:0] tail_i,
    output logic [LINE_BYTES-1:0] be_o
);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        assign be_o[b] = (!first_i || (LINE_SHIFT'(b) >= head_i)) &&
                         (!last_i  || (LINE_SHIFT'(b) <= tail_i));
    end

endmodule

// File: rtl/bfetch_fence.sv
module bfetch_fence #(
    parameter int unsigned ADDR_W = bfetch_pkg::DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0] line_addr_i,
    input  logic [ADDR_W-1:0] fence_i,
    output logic              blocked_o
);

    logic fence_on;

    assign fence_on  = (fence_i != '0);
    assign blocked_o = fence_on && (line_addr_i >= fence_i);

endmodule

// File: rtl/bfetch_ctrl.sv
module bfetch_ctrl
    import bfetch_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned OFFS_W     = DEF_OFFS_W,
    parameter int unsigned LEN_W      = DEF_LEN_W,
    parameter int unsigned LINE_SHIFT = 6,
    parameter int unsigned PAGE_SHIFT = 12,
    localparam int unsigned LINE_W    = ADDR_W - LINE_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [OFFS_W-1:0]     offset_i,
    input  logic [LEN_W-1:0]      length_i,
    input  logic [ADDR_W-1:0]     bound_i,
    input  logic                  req_ready_i,
    input  logic                  blocked_i,
    output logic                  req_valid_o,
    output logic [LINE_W-1:0]     line_o,
    output logic                  first_o,
    output logic                  last_o,
    output logic [LINE_SHIFT-1:0] head_o,
    output logic [LINE_SHIFT-1:0] tail_o,
    output logic [ADDR_W-1:0]     fence_o,
    output logic                  done_o,
    output logic                  bound_hit_o
);

    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));

    typedef struct packed {
        logic [LINE_W-1:0]     cur;
        logic [LINE_W-1:0]     last;
        logic [LINE_SHIFT-1:0] head;
        logic [LINE_SHIFT-1:0] tail;
        logic [ADDR_W-1:0]     fence;
        logic                  first;
    } job_t;

    fstate_e          state_q;
    job_t             job_q;
    job_t             cap;
    logic             done_q;
    logic             hit_q;
    logic [ADDR_W-1:0] s_addr;
    logic [ADDR_W-1:0] e_addr;
    logic             at_last;
    logic             zero_len;

    always_comb begin
        s_addr    = (base_i & PAGE_MASK) + ADDR_W'(offset_i);
        e_addr    = s_addr + ADDR_W'(length_i) - ADDR_W'(1);
        cap.cur   = s_addr[ADDR_W-1:LINE_SHIFT];
        cap.last  = e_addr[ADDR_W-1:LINE_SHIFT];
        cap.head  = s_addr[LINE_SHIFT-1:0];
        cap.tail  = e_addr[LINE_SHIFT-1:0];
        cap.fence = bound_i & PAGE_MASK;
        cap.first = 1'b1;
        zero_len  = (length_i == '0);
    end

    assign at_last = (job_q.cur == job_q.last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            job_q   <= '0;
            done_q  <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    if (start_i) begin
                        job_q   <= cap;
                        hit_q   <= 1'b0;
                        done_q  <= zero_len;
                        state_q <= zero_len ? FS_IDLE : FS_RUN;
                    end
                end
                FS_RUN: begin
                    if (blocked_i) begin
                        state_q <= FS_IDLE;
                        done_q  <= 1'b1;
                        hit_q   <= 1'b1;
                    end else if (req_ready_i) begin
                        if (at_last) begin
                            state_q <= FS_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            job_q.cur   <= job_q.cur + LINE_W'(1);
                            job_q.first <= 1'b0;
                        end
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    assign req_valid_o = (state_q == FS_RUN) && !blocked_i;
    assign line_o      = job_q.cur;
    assign first_o     = job_q.first;
    assign last_o      = at_last;
    assign head_o      = job_q.head;
    assign tail_o      = job_q.tail;
    assign fence_o     = job_q.fence;
    assign done_o      = done_q;
    assign bound_hit_o = hit_q;

    // R4: a stalled request keeps its line
    a_r4_hold_req: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(line_o)));

    // R2: accepted non-final request moves to the next line
    a_r2_line_step: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_ready_i && !last_o) |=> (line_o == $past(line_o) + LINE_W'(1)));

    // R5: zero length finishes at the accepting edge
    a_r5_zero_len: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_q == FS_IDLE && length_i == '0) |=> (done_o && !req_valid_o));

    // R8: flags clear only through a start
    a_r8_done_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(done_o) |-> $past(start_i));

    a_r8_hit_has_done: assert property (@(posedge clk) disable iff (rst)
        bound_hit_o |-> done_o);

endmodule

// File: rtl/bfetch_gen.sv
module bfetch_gen
    import bfetch_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned OFFS_W     = DEF_OFFS_W,
    parameter int unsigned LEN_W      = DEF_LEN_W,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned PAGE_BYTES = DEF_PAGE_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [OFFS_W-1:0]     offset_i,
    input  logic [LEN_W-1:0]      length_i,
    input  logic [ADDR_W-1:0]     bound_i,
    output logic                  req_valid_o,
    input  logic                  req_ready_i,
    output logic [ADDR_W-1:0]     req_addr_o,
    output logic [LINE_BYTES-1:0] req_be_o,
    output logic                  done_o,
    output logic                  bound_hit_o
);

    localparam int unsigned LINE_SHIFT = $clog2(LINE_BYTES);
    localparam int unsigned PAGE_SHIFT = $clog2(PAGE_BYTES);
    localparam int unsigned LINE_W     = ADDR_W - LINE_SHIFT;

    logic [LINE_W-1:0]     line;
    logic                  first;
    logic                  last;
    logic [LINE_SHIFT-1:0] head;
    logic [LINE_SHIFT-1:0] tail;
    logic [ADDR_W-1:0]     fence;
    logic                  blocked;

    bfetch_ctrl #(
        .ADDR_W    (ADDR_W),
        .OFFS_W    (OFFS_W),
        .LEN_W     (LEN_W),
        .LINE_SHIFT(LINE_SHIFT),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .base_i     (base_i),
        .offset_i   (offset_i),
        .length_i   (length_i),
        .bound_i    (bound_i),
        .req_ready_i(req_ready_i),
        .blocked_i  (blocked),
        .req_valid_o(req_valid_o),
        .line_o     (line),
        .first_o    (first),
        .last_o     (last),
        .head_o     (head),
        .tail_o     (tail),
        .fence_o    (fence),
        .done_o     (done_o),
        .bound_hit_o(bound_hit_o)
    );

    assign req_addr_o = {line, {LINE_SHIFT{1'b0}}};

    bfetch_fence #(
        .ADDR_W(ADDR_W)
    ) u_fence (
        .line_addr_i(req_addr_o),
        .fence_i    (fence),
        .blocked_o  (blocked)
    );

    bfetch_bemask #(
        .LINE_BYTES(LINE_BYTES)
    ) u_bemask (
        .first_i(first),
        .last_i (last),
        .head_i (head),
        .tail_i (tail),
        .be_o   (req_be_o)
    );

    // R3: every issued line carries at least one enabled byte
    a_r3_be_nonzero: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> (req_be_o != '0));

    // R6: a finished job presents no request
    a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !req_valid_o);

endmodule

// File: tb/bfetch_gen_tb.sv
`timescale 1ns/1ps
module bfetch_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [63:0] base_i = '0;
    logic [28:0] offset_i = '0;
    logic [27:0] length_i = '0;
    logic [63:0] bound_i = '0;
    logic        req_ready_i = 1'b0;
    logic        req_valid_o;
    logic [63:0] req_addr_o;
    logic [63:0] req_be_o;
    logic        done_o;
    logic        bound_hit_o;

    int checks = 0;
    int errors = 0;
    int hs_cnt = 0;
    int cyc    = 0;
    bit always_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    bfetch_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .base_i     (base_i),
        .offset_i   (offset_i),
        .length_i   (length_i),
        .bound_i    (bound_i),
        .req_valid_o(req_valid_o),
        .req_ready_i(req_ready_i),
        .req_addr_o (req_addr_o),
        .req_be_o   (req_be_o),
        .done_o     (done_o),
        .bound_hit_o(bound_hit_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    // consumer back-pressure pattern
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        req_ready_i = always_ready | lfsr[0] | lfsr[3];
    end

    // behavioural reference model
    logic [63:0] m_cur, m_last, m_fence;
    int          m_head, m_tail;
    bit          m_run = 0, m_first = 0, m_done = 0, m_hit = 0;

    always @(posedge clk) begin
        logic [63:0] s, e;
        if (rst) begin
            m_run = 0; m_done = 0; m_hit = 0;
        end else if (m_run) begin
            if (m_fence != 0 && m_cur >= m_fence) begin
                m_run = 0; m_done = 1; m_hit = 1;
            end else if (req_ready_i) begin
                if (m_cur == m_last) begin
                    m_run = 0; m_done = 1;
                end else begin
                    m_cur = m_cur + 64;
                    m_first = 0;
                end
            end
        end else if (start_i) begin
            s = (base_i & ~64'hFFF) + {35'd0, offset_i};
            e = s + {36'd0, length_i} - 64'd1;
            m_cur   = s & ~64'h3F;
            m_last  = e & ~64'h3F;
            m_head  = int'(s[5:0]);
            m_tail  = int'(e[5:0]);
            m_fence = bound_i & ~64'hFFF;
            m_first = 1;
            m_hit   = 0;
            m_done  = (length_i == 0);
            m_run   = (length_i != 0);
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        bit          ev;
        logic [63:0] eb;
        cyc++;
        if (!rst) begin
            ev = m_run && !(m_fence != 0 && m_cur >= m_fence);
            chk(req_valid_o == ev, "R2 R4 R6 R9 valid", {63'd0, req_valid_o}, {63'd0, ev});
            if (ev && req_valid_o) begin
                chk(req_addr_o == m_cur, "R1 R2 R4 addr", req_addr_o, m_cur);
                for (int i = 0; i < 64; i++)
                    eb[i] = (!m_first || i >= m_head) && (m_cur != m_last || i <= m_tail);
                chk(req_be_o == eb, "R3 byte enables", req_be_o, eb);
            end
            chk(done_o == m_done, "R5 R8 done", {63'd0, done_o}, {63'd0, m_done});
            chk(bound_hit_o == m_hit, "R6 R8 bound_hit", {63'd0, bound_hit_o}, {63'd0, m_hit});
            if (req_valid_o && req_ready_i) hs_cnt++;
        end
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int exp_reqs(logic [63:0] b, logic [28:0] o, logic [27:0] l,
                                    logic [63:0] bd, output bit hit);
        logic [63:0] s, e, sl, el, n, bm, lim;
        hit = 0;
        if (l == 0) return 0;
        s  = (b & ~64'hFFF) + {35'd0, o};
        e  = s + {36'd0, l} - 1;
        sl = s >> 6;
        el = e >> 6;
        n  = el - sl + 1;
        bm = bd & ~64'hFFF;
        if (bm != 0) begin
            if ((sl << 6) >= bm) begin hit = 1; return 0; end
            lim = (bm >> 6) - sl;
            if (lim < n) begin n = lim; hit = 1; end
        end
        return int'(n);
    endfunction

    task automatic run_job(input logic [63:0] b, input logic [28:0] o, input logic [27:0] l,
                           input logic [63:0] bd, input bit disturb, input string tag);
        int  exp_n, wait_c;
        bit  exp_hit;
        exp_n = exp_reqs(b, o, l, bd, exp_hit);
        @(posedge clk); #1;
        base_i = b; offset_i = o; length_i = l; bound_i = bd;
        start_i = 1'b1;
        hs_cnt = 0;
        @(posedge clk); #1;
        start_i = 1'b0;
        if (disturb) begin
            // R9: inputs change and a second start arrives mid-run
            base_i = 64'h7777_0000; offset_i = 29'd3; length_i = 28'd1; bound_i = 64'h1000;
            @(posedge clk); #1;
            start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        wait_c = 0;
        @(negedge clk);
        while (!done_o && wait_c < 20000) begin
            @(negedge clk);
            wait_c++;
        end
        #1;
        chk(hs_cnt == exp_n, {tag, " request count"}, 64'(hs_cnt), 64'(exp_n));
        chk(bound_hit_o == exp_hit, {tag, " bound flag at end"}, {63'd0, bound_hit_o}, {63'd0, exp_hit});
        chk(done_o == 1'b1, {tag, " done at end"}, {63'd0, done_o}, 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        chk(req_valid_o == 0, "R10 reset valid", {63'd0, req_valid_o}, 64'd0);
        chk(done_o == 0, "R10 reset done", {63'd0, done_o}, 64'd0);
        chk(bound_hit_o == 0, "R10 reset bound_hit", {63'd0, bound_hit_o}, 64'd0);

        // R1 R3: single line, base low bits ignored
        run_job(64'h0001_0ABC, 29'd5, 28'd10, 64'd0, 0, "R1 R3 single line");
        // R3: crosses one line boundary
        run_job(64'h0002_0000, 29'd60, 28'd10, 64'd0, 0, "R3 two lines");
        // R2: aligned multi-line
        run_job(64'h0003_0000, 29'h100, 28'd256, 64'd0, 0, "R2 aligned run");
        // R5: zero length
        run_job(64'h0004_0000, 29'd17, 28'd0, 64'd0, 0, "R5 zero length");
        // R6: fence inside the job
        run_job(64'h0002_0000, 29'hF80, 28'd512, 64'h0002_1000, 0, "R6 fence mid job");
        repeat (5) @(negedge clk);
        #1 chk(bound_hit_o == 1 && done_o == 1, "R8 flags sticky", {62'd0, bound_hit_o, done_o}, 64'd3);
        // R6: fence at or below start line
        run_job(64'h0002_0000, 29'h40, 28'd100, 64'h0002_0000, 0, "R6 fence below start");
        // R7: fence with only low bits set is disabled
        run_job(64'h0000_0000, 29'hF00, 28'd700, 64'h0000_0FFF, 0, "R7 low-bit fence");
        // R7: zero fence, long job
        always_ready = 1'b1;
        run_job(64'hFFFF_F000, 29'h1FFF_FFC0, 28'd2000, 64'd0, 0, "R7 zero fence");
        always_ready = 1'b0;
        // R9: mid-run disturbance
        run_job(64'h0005_0000, 29'd9, 28'd600, 64'h0000_0000, 1, "R9 mid-run start");
        // R8: new start clears a previous bound hit
        run_job(64'h0006_0000, 29'd0, 28'd64, 64'h0006_0000, 0, "R6 immediate fence");
        run_job(64'h0006_0000, 29'd0, 28'd64, 64'h0007_0000, 0, "R8 cleared by start");
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule